// File: doc/BRIEF.md
# Service-Window Watchdog with Slow-Clock Monitor

This block supervises a processor core from its instruction-cycle clock. A free-running 16-bit down counter provides the time base. It raises a periodic tick interrupt, and it paces the release of a shared error output. Two fault sources sit on top of it.

The first is a windowed watchdog. Software must pulse a service strobe neither too early nor too late after the previous restart. The second is a clock monitor. It counts cycle-clock edges during each period of a slow reference clock and flags the cycle clock as too slow when the count is short.

Each source owns a small hold-off state machine with four states:

- `HO_CLEAR`: no fault.
- `HO_LATCHED`: fault held.
- `HO_WAIT_A`: waiting for the first hold-off tick.
- `HO_WAIT_B`: waiting for the second hold-off tick.

The transitions are as follows:

- A fault pulse moves any state to `HO_LATCHED`.
- A clear pulse moves `HO_LATCHED` to `HO_WAIT_A`.
- A hold-off tick (each change of timer bit 4) moves `HO_WAIT_A` to `HO_WAIT_B`.
- A further hold-off tick moves `HO_WAIT_B` to `HO_CLEAR`.

The error output is driven low, with its enable high, while any source is outside `HO_CLEAR`. The output is never driven during reset.

The watchdog window is selected by a 2-bit code taken on each accepted service. The code resets to 3, the largest window. The clock-monitor state machine resets into `HO_LATCHED`, so a clock that has not been shown fast enough when reset ends is reported as a fault.

Top module: `wdt_clkmon`

## Requirements
- R1: The idle timer counts down by one every cycle from all-ones after reset. Its tick pending flag sets on every change of bit 12, so pending events are exactly 4096 cycles apart.
- R2: `tick_irq` is the pending flag gated by `tick_en`. A pending flag persists while `tick_en` is 0. `tick_ack` high at a clock edge clears the flag.
- R3: While `rst_n` is low, `err_oe` is 0, `err_n` is 1 and `tick_irq` is 0.
- R4: Leaving reset, the window code is 3 and the clock monitor is already in its fault state. The error output is therefore asserted until a good reference period has been measured.
- R5: A service strobe that arrives fewer than window/8 cycles after the last restart is a watchdog fault.
- R6: When no service arrives within `window` cycles of the last restart, a watchdog fault is raised. Every service or fault restarts the count.
- R7: An accepted service loads the window code from `win_sel`, where window = 2^(WIN_LOG2_MAX-3+code).
- R8: At the second and every later rising edge of the synchronized `ref_clk`, the cycles since the previous rising edge are compared with `cm_min`. A count below `cm_min` is a clock-monitor fault, and a count of at least `cm_min` clears it.
- R9: While any source is faulted or holding off, `err_n`=0 and `err_oe`=1. After its clear, a source releases the pin between 17 and 32 cycles later, and the pin is released only when every source is clear.
- R10: A fault stays latched until its own clear arrives. For the watchdog this is an accepted service; for the monitor it is a good period. The fault does not time out by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_strobe | input | 1 | One-cycle watchdog service pulse |
| win_sel | input | 2 | Window code applied on an accepted service |
| ref_clk | input | 1 | Slow reference clock, asynchronous |
| cm_min | input | CM_W | Minimum cycle-clock edges per reference period |
| tick_en | input | 1 | Tick interrupt enable |
| tick_ack | input | 1 | Clears the tick pending flag |
| err_n | output | 1 | Error pin value, low when a fault is active |
| err_oe | output | 1 | Error pin drive enable, 0 means high impedance |
| tick_irq | output | 1 | Idle-timer tick interrupt |

## Verification
Watchdog faults and clears act at the clock edge that samples the strobe, or when the count reaches its limit. The error enable changes at that same edge. The bench therefore samples a few cycles after each strobe, and a few cycles either side of the expected expiry.

The reference clock passes a three-stage synchronizer, so monitor results lag a reference rising edge by about three cycles. Those checks allow whole reference periods of margin.

Hold-off release falls 17 to 32 cycles after a clear. The bench samples once at 12 cycles, where the pin must still be driven, and once past 40 cycles, where it must be free. The tick check compares the cycle numbers of two interrupt rises, so it does not depend on any single sampling point.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
    typedef enum logic [1:0] {
        HO_CLEAR,
        HO_LATCHED,
        HO_WAIT_A,
        HO_WAIT_B
    } ho_state_t;

    localparam int SRC_WD  = 0;
    localparam int SRC_CM  = 1;
    localparam int NUM_SRC = 2;
endpackage

// File: rtl/wdc_idle_timer.sv
module wdc_idle_timer #(
    parameter int IT_W     = 16,
    parameter int TICK_BIT = 12,
    parameter int HOLD_BIT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            tick_ack,
    output logic [IT_W-1:0] cnt,
    output logic            tick_tgl,
    output logic            hold_tgl,
    output logic            tick_irq
);
    logic prev_tick_q;
    logic prev_hold_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '1;
            prev_tick_q <= 1'b1;
            prev_hold_q <= 1'b1;
            pend_q      <= 1'b0;
        end else begin
            cnt         <= cnt - 1'b1;
            prev_tick_q <= cnt[TICK_BIT];
            prev_hold_q <= cnt[HOLD_BIT];
            if (tick_tgl)
                pend_q <= 1'b1;
            else if (tick_ack)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        tick_tgl = cnt[TICK_BIT] ^ prev_tick_q;
        hold_tgl = cnt[HOLD_BIT] ^ prev_hold_q;
        tick_irq = pend_q & tick_en;
    end
endmodule

// File: rtl/wdc_window_wd.sv
module wdc_window_wd #(
    parameter int WIN_LOG2_MAX = 16,
    parameter int EARLY_SHIFT  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc,
    input  logic [1:0] win_sel,
    output logic       flt_set,
    output logic       flt_clr
);
    localparam int EL_W = WIN_LOG2_MAX + 1;
    localparam int BASE = WIN_LOG2_MAX - 3;

    logic [EL_W-1:0] el_q;
    logic [1:0]      code_q;
    logic [EL_W-1:0] upper;
    logic [EL_W-1:0] lower;
    logic            early;
    logic            late;

    always_comb begin
        upper   = EL_W'(1) << (BASE + int'(code_q));
        lower   = upper >> EARLY_SHIFT;
        early   = svc && (el_q < lower);
        late    = !svc && (el_q == upper - 1'b1);
        flt_set = early || late;
        flt_clr = svc && !early;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            el_q   <= '0;
            code_q <= 2'b11;
        end else begin
            if (svc || late)
                el_q <= '0;
            else
                el_q <= el_q + 1'b1;
            if (flt_clr)
                code_q <= win_sel;
        end
    end
endmodule

// File: rtl/wdc_clk_mon.sv
module wdc_clk_mon #(
    parameter int CM_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_clk,
    input  logic [CM_W-1:0] cm_min,
    output logic            flt_set,
    output logic            flt_clr
);
    logic [2:0]      sync_q;
    logic            primed_q;
    logic [CM_W-1:0] cnt_q;
    logic [CM_W:0]   period;
    logic            ref_rise;

    always_comb begin
        ref_rise = sync_q[1] & ~sync_q[2];
        period   = {1'b0, cnt_q} + 1'b1;
        flt_set  = ref_rise && primed_q && (period < {1'b0, cm_min});
        flt_clr  = ref_rise && primed_q && !flt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '0;
            primed_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ref_clk};
            if (ref_rise) begin
                cnt_q    <= '0;
                primed_q <= 1'b1;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdc_holdoff.sv
module wdc_holdoff
    import wdc_pkg::*;
#(
    parameter bit START_LATCHED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_f,
    input  logic clr_f,
    input  logic tgl,
    output logic busy
);
    localparam ho_state_t RST_STATE = START_LATCHED ? HO_LATCHED : HO_CLEAR;

    ho_state_t state_q;
    ho_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RST_STATE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (set_f) begin
            state_d = HO_LATCHED;
        end else begin
            unique case (state_q)
                HO_CLEAR:   state_d = HO_CLEAR;
                HO_LATCHED: if (clr_f) state_d = HO_WAIT_A;
                HO_WAIT_A:  if (tgl)   state_d = HO_WAIT_B;
                HO_WAIT_B:  if (tgl)   state_d = HO_CLEAR;
                default:    state_d = HO_LATCHED;
            endcase
        end
    end

    always_comb begin
        busy = (state_q != HO_CLEAR);
    end
endmodule

// File: rtl/wdt_clkmon.sv
module wdt_clkmon
    import wdc_pkg::*;
#(
    parameter int IT_W         = 16,
    parameter int TICK_BIT     = 12,
    parameter int HOLD_BIT     = 4,
    parameter int WIN_LOG2_MAX = 16,
    parameter int EARLY_SHIFT  = 3,
    parameter int CM_W         = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            svc_strobe,
    input  logic [1:0]      win_sel,
    input  logic            ref_clk,
    input  logic [CM_W-1:0] cm_min,
    input  logic            tick_en,
    input  logic            tick_ack,
    output logic            err_n,
    output logic            err_oe,
    output logic            tick_irq
);
    logic [IT_W-1:0]    idle_cnt;
    logic               tick_tgl;
    logic               hold_tgl;
    logic               run_q;
    logic [NUM_SRC-1:0] flt_set;
    logic [NUM_SRC-1:0] flt_clr;
    logic [NUM_SRC-1:0] src_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= 1'b1;
    end

    wdc_idle_timer #(
        .IT_W(IT_W), .TICK_BIT(TICK_BIT), .HOLD_BIT(HOLD_BIT)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick_ack(tick_ack),
        .cnt(idle_cnt), .tick_tgl(tick_tgl), .hold_tgl(hold_tgl),
        .tick_irq(tick_irq)
    );

    wdc_window_wd #(
        .WIN_LOG2_MAX(WIN_LOG2_MAX), .EARLY_SHIFT(EARLY_SHIFT)
    ) u_wd (
        .clk(clk), .rst_n(rst_n), .svc(svc_strobe), .win_sel(win_sel),
        .flt_set(flt_set[SRC_WD]), .flt_clr(flt_clr[SRC_WD])
    );

    wdc_clk_mon #(
        .CM_W(CM_W)
    ) u_cm (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .cm_min(cm_min),
        .flt_set(flt_set[SRC_CM]), .flt_clr(flt_clr[SRC_CM])
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        wdc_holdoff #(
            .START_LATCHED(g == SRC_CM)
        ) u_ho (
            .clk(clk), .rst_n(rst_n), .set_f(flt_set[g]), .clr_f(flt_clr[g]),
            .tgl(hold_tgl), .busy(src_busy[g])
        );
    end

    always_comb begin
        err_oe = run_q & (|src_busy);
        err_n  = ~err_oe;
    end
endmodule

// File: rtl/wdc_checker.sv
module wdc_checker #(
    parameter int IT_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            err_oe,
    input logic            tick_irq,
    input logic            tick_ack,
    input logic            tick_tgl,
    input logic            run_q,
    input logic [IT_W-1:0] idle_cnt,
    input logic [1:0]      flt_set
);
    // R3
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!err_oe && !tick_irq);
        end
    end

    // R1
    idle_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> idle_cnt == IT_W'($past(idle_cnt) - 1'b1));

    // R2
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ack && !tick_tgl) |=> !tick_irq);

    // R9
    fault_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (|flt_set)) |=> err_oe);

    // R9
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_oe) |-> ($past(flt_set) == 2'b00));
endmodule

bind wdt_clkmon wdc_checker #(.IT_W(IT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_oe(err_oe), .tick_irq(tick_irq),
    .tick_ack(tick_ack), .tick_tgl(tick_tgl), .run_q(run_q),
    .idle_cnt(idle_cnt), .flt_set(flt_set)
);

// File: tb/wdt_clkmon_test.sv
module wdt_clkmon_test;
    localparam int CM_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            svc_strobe = 1'b0;
    logic [1:0]      win_sel = 2'b00;
    logic            ref_clk = 1'b0;
    logic [CM_W-1:0] cm_min = 8'd20;
    logic            tick_en = 1'b0;
    logic            tick_ack = 1'b0;
    logic            err_n;
    logic            err_oe;
    logic            tick_irq;

    int n_run  = 0;
    int n_fail = 0;
    int ref_half = 0;
    int ref_cnt  = 0;

    always #4ns clk = ~clk;

    wdt_clkmon #(.WIN_LOG2_MAX(10), .CM_W(CM_W)) uut (
        .clk(clk), .rst_n(rst_n), .svc_strobe(svc_strobe), .win_sel(win_sel),
        .ref_clk(ref_clk), .cm_min(cm_min), .tick_en(tick_en),
        .tick_ack(tick_ack), .err_n(err_n), .err_oe(err_oe), .tick_irq(tick_irq)
    );

    always @(negedge clk) begin
        if (ref_half > 0) begin
            if (ref_cnt >= ref_half - 1) begin
                ref_clk <= ~ref_clk;
                ref_cnt <= 0;
            end else begin
                ref_cnt <= ref_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic serve(input logic [1:0] sel);
        @(negedge clk);
        svc_strobe = 1'b1;
        win_sel    = sel;
        @(negedge clk);
        svc_strobe = 1'b0;
    endtask

    task automatic t_reset();
        idle(10);
        check("R3 err_oe in reset", int'(err_oe), 0);
        check("R3 err_n in reset", int'(err_n), 1);
        check("R3 tick_irq in reset", int'(tick_irq), 0);
        rst_n    = 1'b1;
        ref_half = 20;
    endtask

    task automatic t_boot();
        idle(60);
        check("R4 monitor armed at reset end", int'(err_oe), 1);
        check("R9 pin low with fault", int'(err_n), 0);
        idle(140);
        check("R9 released after good period", int'(err_oe), 0);
    endtask

    task automatic t_wd_max();
        idle(500);
        check("R4 largest window after reset", int'(err_oe), 0);
        serve(2'd0);
        idle(5);
        check("R7 valid service no fault", int'(err_oe), 0);
    endtask

    task automatic t_wd_early();
        serve(2'd0);
        idle(3);
        check("R5 early service faults", int'(err_oe), 1);
        idle(30);
        serve(2'd0);
        idle(12);
        check("R9 hold-off keeps pin low", int'(err_oe), 1);
        idle(30);
        check("R9 pin released after hold-off", int'(err_oe), 0);
    endtask

    task automatic t_wd_expire();
        serve(2'd0);
        idle(120);
        check("R6 no fault inside window", int'(err_oe), 0);
        idle(15);
        check("R6 expiry faults", int'(err_oe), 1);
        idle(28);
        check("R10 fault stays latched", int'(err_oe), 1);
        serve(2'd0);
        idle(12);
        check("R10 hold-off after clear", int'(err_oe), 1);
        idle(30);
        check("R10 released after clear", int'(err_oe), 0);
    endtask

    task automatic t_wd_sel();
        serve(2'd1);
        idle(20);
        serve(2'd1);
        idle(3);
        check("R7 lower bound scales with code", int'(err_oe), 1);
        idle(40);
        serve(2'd1);
        idle(12);
        check("R9 held after sel clear", int'(err_oe), 1);
        idle(40);
        check("R7 released after sel clear", int'(err_oe), 0);
        idle(150);
        check("R7 upper bound scales with code", int'(err_oe), 0);
        serve(2'd3);
    endtask

    task automatic t_cm_slow();
        ref_half = 5;
        idle(40);
        check("R8 slow clock faults", int'(err_oe), 1);
        ref_half = 20;
        idle(150);
        check("R8 good period clears", int'(err_oe), 0);
    endtask

    task automatic t_tick();
        int rises = 0;
        int rise_cyc[2];
        int since = 0;
        logic acked = 1'b0;
        tick_en = 1'b1;
        for (int k = 0; k < 10000 && rises < 2; k++) begin
            @(negedge clk);
            tick_ack   = 1'b0;
            since++;
            svc_strobe = (since >= 600);
            win_sel    = 2'd3;
            if (since >= 600) since = 0;
            if (acked) begin
                check("R2 ack clears irq", int'(tick_irq), 0);
                acked = 1'b0;
            end
            if (tick_irq) begin
                rise_cyc[rises] = k;
                rises++;
                tick_ack = 1'b1;
                acked    = 1'b1;
            end
        end
        @(negedge clk);
        tick_ack   = 1'b0;
        svc_strobe = 1'b0;
        check("R1 two ticks seen", rises, 2);
        check("R1 tick period", rise_cyc[1] - rise_cyc[0], 4096);
        tick_en = 1'b0;
        for (int k = 0; k < 4300; k++) begin
            @(negedge clk);
            since++;
            svc_strobe = (since >= 600);
            if (since >= 600) since = 0;
        end
        @(negedge clk);
        svc_strobe = 1'b0;
        check("R2 masked irq stays low", int'(tick_irq), 0);
        check("R6 serviced watchdog quiet", int'(err_oe), 0);
        tick_en = 1'b1;
        @(negedge clk);
        check("R2 pending kept while masked", int'(tick_irq), 1);
    endtask

    initial begin
        #(8ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_boot();
        t_wd_max();
        t_wd_early();
        t_wd_expire();
        t_wd_sel();
        t_cm_slow();
        t_tick();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule